// File: doc/BRIEF.md
# Microcoded Control Word Sequencer

This block is the control unit of a small 8-bit accumulator processor. A short step counter walks through the microcode of the current instruction. For each pair of opcode and step, a lookup produces a 32-bit control word that drives the datapath's load, output, memory and counter enables. Every control line rests at 1 and is asserted by driving it to 0. As a result, a microcode entry only has to name the lines it asserts.

Step 0 is shared by every instruction. It fetches the next opcode from memory into the instruction register and advances the program counter. The action steps of the opcode follow. After the last action step comes a step that asserts only the active-low counter clear. That clear acts on the counter flip-flops without waiting for a clock edge, so the clear step lasts no visible cycle and the next sampled step is a fetch.

Three bus writers must never drive the bus together: the ALU result, the upper half of the accumulator and the upper half of the data register. They share a 2-bit field in the control word. A 2-to-4 decode turns that field into separate active-low enables, and the all-ones value of the field selects no writer.

Top module: `ucode_ctrl_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the step counter goes to 0. Immediately after that edge `step` reads 0, `ctrl_n` equals 32'hFFFF_FFF0 (the fetch word) and `wr_en_n` equals 3'b111. This also applies when reset arrives in the middle of an instruction.
- R2: In step 0 the output is the fetch word for every opcode. Bits 0 (address from PC), 1 (memory read), 2 (instruction register load) and 3 (PC increment) are 0, and every other bit is 1.
- R3: On each clock edge without reset, the step counter advances by exactly one, except when it is cleared.
- R4: Bit 31 of the control word is the active-low counter clear. The lookup drives it low only on the step after an opcode's last action step, and it clears the counter immediately. The cycle that follows the last action step is therefore always step 0, and bit 31 is high in every sampled cycle.
- R5: Opcode 8'h01 (load immediate) has one action step with word 32'hFFFF_FFE4: bits 0, 1, 3 and 4 (accumulator load) are low.
- R6: The writer code sits in `ctrl_n[13:12]`. Code 00 drives `wr_en_n[0]` low (ALU result). Code 01 drives `wr_en_n[1]` low (accumulator upper half). Code 10 drives `wr_en_n[2]` low (data register upper half). Code 11 leaves all three high. Opcode 8'h02 has one action step with word 32'hFFFF_DFDF (code 01, bit 5 low: U load). Opcode 8'h03 has one action step with word 32'hFFFF_EFBF (code 10, bit 6 low: V load).
- R7: At most one bit of `wr_en_n` is ever low.
- R8: Any opcode not listed in R5, R6, R9 or R10 executes as a fetch followed directly by the counter clear, so it occupies exactly one cycle.
- R9: Opcode 8'h04 (store accumulator) has two action steps. The first has word 32'hFFFF_F5FE (bits 0, 9 memory write and 11 accumulator output low). The second has word 32'hFFFF_FFF7 (bit 3 low).
- R10: An opcode whose bits [7:6] are 01 is an ALU operation with one action step. Its word has writer code 00, bit 4 low, `ctrl_n[16:14]` equal to opcode[2:0], and all other bits high.
- R11: Bits 30 to 17 and bit 10 of `ctrl_n` are high in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the step counter |
| opcode | input | 8 | Contents of the instruction register |
| step | output | STEP_W | Current microcode step |
| ctrl_n | output | 32 | Active-low control word |
| wr_en_n | output | NWR | Decoded active-low bus writer enables |

## Verification
The assertions assume that `opcode` holds the value fetched in step 0 without change until the instruction's last action step, as a real instruction register would. They also assume that reset is held for at least two clock edges. The bench keeps within these limits. It changes `opcode` only in a cycle where the step is 0, and it raises reset for at least two edges, both at start-up and when it aborts a store instruction midway. Both the interval from an instruction's fetch to its return to step 0 and every word along the way are checked against lengths and words taken from the requirements.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    localparam int STEP_W_DEF = 2;
    localparam int NWR_DEF    = 3;
    localparam int OP_W       = 8;

    // Control word; every field is active low and rests at 1.
    typedef struct packed {
        logic        clr_n;      // 31 asynchronous counter clear
        logic [13:0] spare_hi;   // 30:17 unused
        logic [2:0]  alu_op;     // 16:14 ALU function
        logic [1:0]  wsel;       // 13:12 encoded bus writer
        logic        a_out;      // 11
        logic        rsvd;       // 10 unused
        logic        mem_wr;     // 9
        logic        v_out;      // 8
        logic        u_out;      // 7
        logic        v_ld;       // 6
        logic        u_ld;       // 5
        logic        a_ld;       // 4
        logic        pc_inc;     // 3
        logic        ir_ld;      // 2
        logic        mem_rd;     // 1
        logic        addr_pc;    // 0
    } ctrl_word_t;

    localparam int CW_W = $bits(ctrl_word_t);

    localparam logic [OP_W-1:0] OP_LDI   = 8'h01;
    localparam logic [OP_W-1:0] OP_AHI_U = 8'h02;
    localparam logic [OP_W-1:0] OP_DHI_V = 8'h03;
    localparam logic [OP_W-1:0] OP_STA   = 8'h04;
    localparam logic [1:0]      ALU_GRP  = 2'b01;

    localparam logic [1:0] WSEL_ALU  = 2'd0;
    localparam logic [1:0] WSEL_AHI  = 2'd1;
    localparam logic [1:0] WSEL_DHI  = 2'd2;
    localparam logic [1:0] WSEL_NONE = 2'd3;

    function automatic ctrl_word_t idle_word();
        ctrl_word_t w;
        w = '1;
        return w;
    endfunction

    function automatic ctrl_word_t fetch_word();
        ctrl_word_t w;
        w         = idle_word();
        w.addr_pc = 1'b0;
        w.mem_rd  = 1'b0;
        w.ir_ld   = 1'b0;
        w.pc_inc  = 1'b0;
        return w;
    endfunction

    function automatic bit is_alu(input logic [OP_W-1:0] op);
        return op[OP_W-1:OP_W-2] == ALU_GRP;
    endfunction

    // Number of action steps between fetch and clear.
    function automatic int act_steps(input logic [OP_W-1:0] op);
        if (is_alu(op)) return 1;
        case (op)
            OP_LDI, OP_AHI_U, OP_DHI_V: return 1;
            OP_STA:                     return 2;
            default:                    return 0;
        endcase
    endfunction

endpackage

// File: rtl/ucode_step_ctr.sv
module ucode_step_ctr #(
    parameter int STEP_W = ucode_pkg::STEP_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    output logic [STEP_W-1:0] step
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            step <= '0;
        end else if (rst) begin
            step <= '0;
        end else begin
            step <= step + 1'b1;
        end
    end

endmodule

// File: rtl/ucode_store.sv
module ucode_store
    import ucode_pkg::*;
#(
    parameter int STEP_W = STEP_W_DEF
) (
    input  logic [OP_W-1:0]   opcode,
    input  logic [STEP_W-1:0] step,
    output ctrl_word_t        word
);

    logic [31:0] step_i;
    int          n_act;

    assign step_i = 32'(step);
    assign n_act  = act_steps(opcode);

    always_comb begin
        word = idle_word();
        if (step == '0) begin
            word = fetch_word();
        end else if (step_i > 32'(n_act)) begin
            word.clr_n = 1'b0;
        end else if (is_alu(opcode)) begin
            word.wsel   = WSEL_ALU;
            word.a_ld   = 1'b0;
            word.alu_op = opcode[2:0];
        end else begin
            case (opcode)
                OP_LDI: begin
                    word.addr_pc = 1'b0;
                    word.mem_rd  = 1'b0;
                    word.a_ld    = 1'b0;
                    word.pc_inc  = 1'b0;
                end
                OP_AHI_U: begin
                    word.wsel = WSEL_AHI;
                    word.u_ld = 1'b0;
                end
                OP_DHI_V: begin
                    word.wsel = WSEL_DHI;
                    word.v_ld = 1'b0;
                end
                OP_STA: begin
                    if (step_i == 32'd1) begin
                        word.addr_pc = 1'b0;
                        word.a_out   = 1'b0;
                        word.mem_wr  = 1'b0;
                    end else begin
                        word.pc_inc  = 1'b0;
                    end
                end
                default: word = idle_word();
            endcase
        end
    end

endmodule

// File: rtl/ucode_wr_decode.sv
module ucode_wr_decode #(
    parameter int NWR   = ucode_pkg::NWR_DEF,
    parameter int ENC_W = $clog2(NWR + 1)
) (
    input  logic [ENC_W-1:0] code,
    output logic [NWR-1:0]   en_n
);

    // The all-ones code stays above every writer index, so it selects none.
    for (genvar g = 0; g < NWR; g++) begin : g_wr
        assign en_n[g] = (code != ENC_W'(g));
    end

endmodule

// File: rtl/ucode_ctrl_seq.sv
module ucode_ctrl_seq
    import ucode_pkg::*;
#(
    parameter int STEP_W = STEP_W_DEF,
    parameter int NWR    = NWR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    output logic [STEP_W-1:0] step,
    output logic [CW_W-1:0]   ctrl_n,
    output logic [NWR-1:0]    wr_en_n
);

    localparam int ENC_W = $clog2(NWR + 1);

    ctrl_word_t word;

    ucode_step_ctr #(.STEP_W(STEP_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .clr_n (word.clr_n),
        .step  (step)
    );

    ucode_store #(.STEP_W(STEP_W)) u_store (
        .opcode (opcode),
        .step   (step),
        .word   (word)
    );

    ucode_wr_decode #(.NWR(NWR), .ENC_W(ENC_W)) u_dec (
        .code (word.wsel[ENC_W-1:0]),
        .en_n (wr_en_n)
    );

    assign ctrl_n = word;

endmodule

// File: rtl/ucode_ctrl_seq_chk.sv
module ucode_ctrl_seq_chk #(
    parameter int STEP_W = ucode_pkg::STEP_W_DEF,
    parameter int NWR    = ucode_pkg::NWR_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic [STEP_W-1:0] step,
    input logic [31:0]       ctrl_n,
    input logic [NWR-1:0]    wr_en_n
);

    // R7
    wr_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~wr_en_n) <= 1);

    // R6
    wr_none_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_n[13:12] == 2'b11) |-> (wr_en_n == '1));

    // R2
    fetch_word_chk: assert property (@(posedge clk) disable iff (rst)
        (step == '0) |-> (ctrl_n == 32'hFFFF_FFF0));

    // R3
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (step == '0 || step == $past(step) + 1'b1));

    // R4
    clr_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_n[31]);

    // R11
    spare_high_chk: assert property (@(posedge clk) disable iff (rst)
        (&ctrl_n[30:17]) && ctrl_n[10]);

endmodule

bind ucode_ctrl_seq ucode_ctrl_seq_chk #(.STEP_W(STEP_W), .NWR(NWR)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .ctrl_n  (ctrl_n),
    .wr_en_n (wr_en_n)
);

// File: tb/ucode_ctrl_seq_test.sv
`timescale 1ns/1ps
module ucode_ctrl_seq_test;

    typedef struct {
        logic [1:0]  stp;
        logic [31:0] ctrl;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode = 8'h00;
    logic [1:0]  step;
    logic [31:0] ctrl_n;
    logic [2:0]  wr_en_n;

    int   tests = 0;
    int   fails = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    ucode_ctrl_seq uut (
        .clk     (clk),
        .rst     (rst),
        .opcode  (opcode),
        .step    (step),
        .ctrl_n  (ctrl_n),
        .wr_en_n (wr_en_n)
    );

    function automatic int n_cycles(input logic [7:0] op);
        if (op[7:6] == 2'b01) return 2;           // R10
        if (op == 8'h01 || op == 8'h02 || op == 8'h03) return 2;
        if (op == 8'h04) return 3;                // R9
        return 1;                                 // R8
    endfunction

    function automatic logic [31:0] exp_word(input logic [7:0] op, input int s);
        if (s == 0) return 32'hFFFF_FFF0;
        if (op[7:6] == 2'b01)
            return (32'hFFFF_CFEF & ~(32'h7 << 14)) | (32'(op[2:0]) << 14);
        case (op)
            8'h01: return 32'hFFFF_FFE4;
            8'h02: return 32'hFFFF_DFDF;
            8'h03: return 32'hFFFF_EFBF;
            8'h04: return (s == 1) ? 32'hFFFF_F5FE : 32'hFFFF_FFF7;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] op, input int s);
        if (s == 0) return "R2";
        if (op[7:6] == 2'b01) return "R10";
        if (op == 8'h01) return "R5";
        if (op == 8'h04) return "R9";
        return "R6";
    endfunction

    // R6 mapping from the encoded field to the enables
    function automatic logic [2:0] exp_wr(input logic [1:0] code);
        case (code)
            2'b00:   return 3'b110;
            2'b01:   return 3'b101;
            2'b10:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Driver: called at a falling edge where the step is 0.
    task automatic run_op(input logic [7:0] op);
        int n;
        n = n_cycles(op);
        opcode = op;
        for (int s = 0; s < n; s++) begin
            exp_t e;
            e.stp  = 2'(s);
            e.ctrl = exp_word(op, s);
            e.tag  = tag_of(op, s);
            q.push_back(e);
        end
        repeat (n) @(negedge clk);
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                // R3 and R4: instruction length and return to fetch
                check(step == e.stp, "R3/R4 step", 32'(step), 32'(e.stp));
                check(ctrl_n == e.ctrl, e.tag, ctrl_n, e.ctrl);
                check(wr_en_n == exp_wr(ctrl_n[13:12]), "R6 enables",
                      32'(wr_en_n), 32'(exp_wr(ctrl_n[13:12])));
                check($countones(~wr_en_n) <= 1, "R7 exclusive", 32'(wr_en_n), 32'h0);
                check((&ctrl_n[30:17]) && ctrl_n[10] && ctrl_n[31], "R11 idle bits",
                      ctrl_n, ctrl_n | 32'hFFFE_0400);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1
        check(step == 2'd0, "R1 step", 32'(step), 32'h0);
        check(ctrl_n == 32'hFFFF_FFF0, "R1 ctrl", ctrl_n, 32'hFFFF_FFF0);
        check(wr_en_n == 3'b111, "R1 enables", 32'(wr_en_n), 32'h7);
        @(negedge clk);
        rst = 1'b0;
        run_op(8'h00);
        run_op(8'h01);
        run_op(8'h02);
        run_op(8'h03);
        run_op(8'h04);
        run_op(8'h40);
        run_op(8'h47);
        run_op(8'h5A);
        run_op(8'h80);
        run_op(8'hFF);
        run_op(8'h05);
        run_op(8'h04);
        run_op(8'h01);
        // R1: reset in the middle of a store
        opcode = 8'h04;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check(step == 2'd0, "R1 mid step", 32'(step), 32'h0);
        check(ctrl_n == 32'hFFFF_FFF0, "R1 mid ctrl", ctrl_n, 32'hFFFF_FFF0);
        @(negedge clk);
        rst = 1'b0;
        run_op(8'h03);
        run_op(8'hC3);
        run_op(8'h7F);
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule